// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Command Engine

This block is the device side of a three-wire serial nonvolatile memory. A host raises chip select, clocks a command frame in on the serial data line, and, for reads, clocks the selected word back out on the serial data output. Seven commands are decoded: read, write, erase, erase-all, write-all, and a pair that opens and closes a write-enable latch. A strap input picks the array organisation: 16-bit words, or 8-bit bytes with one more address bit. The storage is a register file of 16-bit words. In byte mode, each word holds two bytes.

All three host lines are synchronised into the system clock domain, and their edges are found from the synchronised samples. Program operations (write, erase, write-all, erase-all) do not run on the serial clock. Each one arms when its frame completes and starts when chip select falls. It then runs for a fixed number of system clocks, counted internally. While chip select is high during that cycle, the data output reports busy (low) or ready (high).

Top module: `serial_eeprom`

## Requirements
- R1: A frame is a 1 start bit, then 2 opcode bits, then the address, sent MSB first. The address is ADDR_BITS wide when `org_wide`=1 and ADDR_BITS+1 wide when `org_wide`=0. A write or write-all frame adds a 16-bit or 8-bit data field, MSB first.
- R2: Input bits are taken on rising `sclk` edges while `cs` is high. Zero bits that come before the start bit are skipped.
- R3: After the last address bit of a read, `sdo` carries a single 0 dummy bit. The word follows MSB first, and each new bit appears on a rising `sclk` edge.
- R4: While `cs` stays high, a read continues to the next address with no new frame. After the top address it wraps to address 0.
- R5: After reset the enable latch is closed. While it is closed, write, erase, write-all and erase-all change nothing and no busy cycle starts.
- R6: Read works whether the enable latch is open or closed.
- R7: A program operation starts only on the falling edge of `cs` after a complete frame. A frame cut short by `cs` going low does nothing.
- R8: `sdo_en` is 0 whenever `cs` is low. While a program cycle runs and `cs` is high, `sdo` is 0. Once the cycle ends, `sdo` is 1.
- R9: After reset every location reads all ones. Erase and erase-all set locations to all ones. A write replaces the old value with no separate erase.
- R10: The opcodes are 10 read, 01 write and 11 erase. Opcode 00 uses the top two address bits: 11 opens the latch, 00 closes it, 10 is erase-all and 01 is write-all.
- R11: A program cycle lasts PROG_CYCLES system clocks. Any frame sent while it runs is ignored.
- R12: In byte mode, byte address b maps to word b>>1. An even b is bits [7:0] and an odd b is bits [15:8]. A byte-mode write-all fills both halves of every word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| org_wide | input | 1 | 1: 16-bit words, 0: 8-bit bytes |
| cs | input | 1 | Chip select from host |
| sclk | input | 1 | Serial clock from host |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out (read data or busy/ready) |
| sdo_en | output | 1 | Output enable for `sdo`; 0 means high impedance |

## Verification
The bench builds the block with ADDR_BITS=4 and PROG_CYCLES=300. The small array lets the bench write and read back every word and every byte in both organisations, and step reads across the wrap point. The 300-clock cycle is longer than a full write frame sent at the bench's serial rate, so a whole frame can be placed inside a busy cycle to show that it is ignored.

// File: rtl/serial_eeprom.sv
module serial_eeprom #(
  parameter int ADDR_BITS   = 10,
  parameter int PROG_CYCLES = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic org_wide,
  input  logic cs,
  input  logic sclk,
  input  logic sdi,
  output logic sdo,
  output logic sdo_en
);
  localparam int DEPTH = 1 << ADDR_BITS;
  localparam int SHW   = ADDR_BITS + 3;
  localparam int BA    = ADDR_BITS + 1;
  localparam int CNTW  = $clog2(ADDR_BITS + 20);
  localparam int CW    = $clog2(PROG_CYCLES + 1);
  localparam logic [CNTW-1:0] LAST_W = CNTW'(ADDR_BITS + 1);
  localparam logic [CNTW-1:0] LAST_B = CNTW'(ADDR_BITS + 2);
  localparam logic [CW-1:0]   BLAST  = CW'(PROG_CYCLES - 1);

  typedef enum logic [2:0] {S_IDLE=3'd0, S_CMD=3'd1, S_DATA=3'd2, S_RD=3'd3, S_ARM=3'd4, S_SKIP=3'd5} st_t;
  typedef enum logic [2:0] {K_NONE, K_WR, K_ER, K_WRAL, K_ERAL, K_EWEN, K_EWDS} kind_t;

  logic [1:0] cs_p, sk_p, di_p;
  logic       cs_q, sk_q;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      cs_p <= '0; sk_p <= '0; di_p <= '0; cs_q <= 1'b0; sk_q <= 1'b0;
    end else begin
      cs_p <= {cs_p[0], cs}; sk_p <= {sk_p[0], sclk}; di_p <= {di_p[0], sdi};
      cs_q <= cs_p[1]; sk_q <= sk_p[1];
    end

  wire cs_s    = cs_p[1];
  wire di_s    = di_p[1];
  wire sk_rise = cs_s & sk_p[1] & ~sk_q;
  wire cs_fall = cs_q & ~cs_s;

  st_t             st;
  kind_t           kind;
  logic [SHW-1:0]  sh;
  logic [CNTW-1:0] cnt;
  logic [BA-1:0]   p_addr, r_addr;
  logic [15:0]     p_data;
  logic            p_org, do_q, stat, wen, busy;
  logic [3:0]      rd_cnt;
  logic [CW-1:0]   bcnt;
  logic [15:0]     mem [DEPTH];

  wire [SHW-1:0] sh_n = {sh[SHW-2:0], di_s};
  wire [1:0]     op_n = org_wide ? sh_n[ADDR_BITS+1:ADDR_BITS] : sh_n[ADDR_BITS+2:ADDR_BITS+1];
  wire [1:0]     top2 = org_wide ? sh_n[ADDR_BITS-1:ADDR_BITS-2] : sh_n[ADDR_BITS:ADDR_BITS-1];
  wire [BA-1:0]  ad_n = org_wide ? {1'b0, sh_n[ADDR_BITS-1:0]} : sh_n[ADDR_BITS:0];

  wire [ADDR_BITS-1:0] r_wix   = org_wide ? r_addr[ADDR_BITS-1:0] : r_addr[ADDR_BITS:1];
  wire [15:0]          rd_word = mem[r_wix];
  wire [15:0]          rd_val  = org_wide ? rd_word
                                 : {(r_addr[0] ? rd_word[15:8] : rd_word[7:0]), 8'h00};
  wire [ADDR_BITS-1:0] p_wix   = p_org ? p_addr[ADDR_BITS-1:0] : p_addr[ADDR_BITS:1];
  wire                 done    = busy && (bcnt == BLAST);

  assign sdo_en = cs_s & (stat | (st == S_RD));
  assign sdo    = stat ? ~busy : do_q;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      st <= S_IDLE; kind <= K_NONE; sh <= '0; cnt <= '0;
      p_addr <= '0; r_addr <= '0; p_data <= '0; p_org <= 1'b1;
      do_q <= 1'b0; stat <= 1'b0; wen <= 1'b0; busy <= 1'b0;
      rd_cnt <= '0; bcnt <= '0;
    end else begin
      if (busy) begin
        if (done) busy <= 1'b0;
        else      bcnt <= bcnt + 1'b1;
      end
      if (!cs_s) begin
        st <= S_IDLE;
        if (cs_q && st == S_ARM && !busy) begin
          case (kind)
            K_EWEN: wen <= 1'b1;
            K_EWDS: wen <= 1'b0;
            default:
              if (wen) begin busy <= 1'b1; bcnt <= '0; stat <= 1'b1; end
          endcase
        end
      end else if (sk_rise) begin
        case (st)
          S_IDLE:
            if (busy) st <= S_SKIP;
            else if (di_s) begin
              st <= S_CMD; sh <= '0; cnt <= '0; stat <= 1'b0;
            end
          S_CMD: begin
            sh  <= sh_n;
            cnt <= cnt + 1'b1;
            if (cnt == (org_wide ? LAST_W : LAST_B)) begin
              cnt <= '0; p_org <= org_wide; p_addr <= ad_n; p_data <= '0;
              case (op_n)
                2'b10: begin st <= S_RD; r_addr <= ad_n; rd_cnt <= '0; do_q <= 1'b0; end
                2'b01: begin kind <= K_WR; st <= S_DATA; end
                2'b11: begin kind <= K_ER; st <= S_ARM; end
                default:
                  case (top2)
                    2'b11:   begin kind <= K_EWEN; st <= S_ARM; end
                    2'b00:   begin kind <= K_EWDS; st <= S_ARM; end
                    2'b10:   begin kind <= K_ERAL; st <= S_ARM; end
                    default: begin kind <= K_WRAL; st <= S_DATA; end
                  endcase
              endcase
            end
          end
          S_DATA: begin
            p_data <= {p_data[14:0], di_s};
            cnt    <= cnt + 1'b1;
            if (cnt == CNTW'(p_org ? 15 : 7)) st <= S_ARM;
          end
          S_RD: begin
            do_q <= rd_val[4'd15 - rd_cnt];
            if (rd_cnt == (org_wide ? 4'd15 : 4'd7)) begin
              rd_cnt <= '0;
              r_addr <= org_wide ? {1'b0, r_addr[ADDR_BITS-1:0] + 1'b1} : r_addr + 1'b1;
            end else
              rd_cnt <= rd_cnt + 1'b1;
          end
          default: ;
        endcase
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
    end else if (done) begin
      case (kind)
        K_WR, K_ER: begin
          if (p_org)          mem[p_wix]       <= (kind == K_WR) ? p_data : 16'hFFFF;
          else if (p_addr[0]) mem[p_wix][15:8] <= (kind == K_WR) ? p_data[7:0] : 8'hFF;
          else                mem[p_wix][7:0]  <= (kind == K_WR) ? p_data[7:0] : 8'hFF;
        end
        K_WRAL: for (int i = 0; i < DEPTH; i++)
                  mem[i] <= p_org ? p_data : {p_data[7:0], p_data[7:0]};
        K_ERAL: for (int i = 0; i < DEPTH; i++) mem[i] <= 16'hFFFF;
        default: ;
      endcase
    end
endmodule

// File: rtl/serial_eeprom_chk.sv
module serial_eeprom_chk #(
  parameter int PROG_CYCLES = 64,
  parameter int CW = 7
) (
  input logic          clk,
  input logic          rst_n,
  input logic          busy,
  input logic          wen,
  input logic          cs_s,
  input logic          cs_q,
  input logic          sdo,
  input logic          sdo_en,
  input logic [CW-1:0] bcnt,
  input logic [2:0]    st
);
  assert_locked_no_cycle_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> wen);
  assert_start_on_deselect_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(cs_q && !cs_s));
  assert_busy_reads_low_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && sdo_en) |-> !sdo);
  assert_hiz_when_deselected_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !cs_s |-> !sdo_en);
  assert_cycle_bounded_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (int'(bcnt) < PROG_CYCLES));
  assert_no_frame_while_busy_R11: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (st != 3'd1 && st != 3'd2 && st != 3'd3));
endmodule

bind serial_eeprom serial_eeprom_chk #(.PROG_CYCLES(PROG_CYCLES), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .wen(wen), .cs_s(cs_s), .cs_q(cs_q),
  .sdo(sdo), .sdo_en(sdo_en), .bcnt(bcnt), .st(st)
);

// File: tb/serial_eeprom_tb.sv
module serial_eeprom_tb;
  localparam int AW   = 4;
  localparam int PROG = 300;
  localparam int NW   = 1 << AW;
  localparam int NB   = 2 * NW;

  logic clk = 1'b0, rst_n = 1'b0, org_wide = 1'b1, cs = 1'b0, sclk = 1'b0, sdi = 1'b0;
  logic sdo, sdo_en;
  int n_cmp = 0, n_bad = 0;
  logic [15:0] mdl [NW];

  always #10 clk = ~clk;

  serial_eeprom #(.ADDR_BITS(AW), .PROG_CYCLES(PROG)) u_dut (
    .clk(clk), .rst_n(rst_n), .org_wide(org_wide), .cs(cs), .sclk(sclk), .sdi(sdi),
    .sdo(sdo), .sdo_en(sdo_en));

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bitx(input logic b, output logic o);
    sdi = b; wait_clk(4);
    o = sdo;
    sclk = 1'b1; wait_clk(4);
    sclk = 1'b0;
  endtask

  task automatic send(input logic [31:0] v, input int n);
    logic o;
    for (int i = n - 1; i >= 0; i--) bitx(v[i], o);
  endtask

  task automatic sel();   cs = 1'b1; wait_clk(3); endtask
  task automatic desel(); cs = 1'b0; sdi = 1'b0; wait_clk(4); endtask

  function automatic int abits(input logic w); return w ? AW : AW + 1; endfunction
  function automatic logic [15:0] wpat(input int a); return 16'(a * 16'h1111) ^ 16'h5A3C; endfunction
  function automatic logic [7:0]  bpat(input int b); return 8'(b * 37 + 11); endfunction
  function automatic logic [7:0]  mbyte(input int b);
    return b[0] ? mdl[b >> 1][15:8] : mdl[b >> 1][7:0];
  endfunction

  task automatic header(input logic [1:0] op, input int addr);
    send({29'd0, 1'b1, op}, 3);
    send(32'(addr), abits(org_wide));
  endtask

  task automatic special(input logic [1:0] top2);
    header(2'b00, int'(top2) << (abits(org_wide) - 2));
  endtask

  // completes a program frame already sent, then checks status on sdo
  task automatic finish_prog(input logic expect_busy, input string req);
    desel(); sel(); wait_clk(3);
    if (expect_busy) begin
      chk({req, " R8 busy drives low"}, {30'd0, sdo_en, sdo}, 32'b10);
      wait_clk(PROG + 10);
      chk({req, " R8 ready drives high"}, {30'd0, sdo_en, sdo}, 32'b11);
    end else
      chk({req, " R5 no cycle started"}, {31'd0, sdo_en}, 32'd0);
    desel();
  endtask

  task automatic do_write(input int addr, input logic [15:0] d, input logic expect_busy, input string req);
    sel(); header(2'b01, addr); send({16'd0, d}, org_wide ? 16 : 8);
    finish_prog(expect_busy, req);
  endtask

  task automatic do_read(input int start, input int n, input int lead0, input string req);
    logic o;
    logic [15:0] v;
    int span, w, a;
    span = org_wide ? NW : NB;
    w = org_wide ? 16 : 8;
    sel();
    send(32'd0, lead0);
    header(2'b10, start);
    bitx(1'b0, o);
    chk({req, " R3 dummy bit"}, {30'd0, sdo_en, o}, 32'b10);
    for (int k = 0; k < n; k++) begin
      v = '0;
      for (int j = 0; j < w; j++) begin bitx(1'b0, o); v = {v[14:0], o}; end
      a = (start + k) % span;
      chk({req, $sformatf(" R1 R4 read addr %0d", a)}, 32'(v),
          org_wide ? 32'(mdl[a]) : 32'(mbyte(a)));
    end
    desel();
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
    wait_clk(5);
    chk("R8 reset output disabled", {31'd0, sdo_en}, 32'd0);
    rst_n = 1'b1; wait_clk(3);

    // R5: locked after reset, write ignored; R9 reset content
    do_write(3, 16'h1234, 1'b0, "R5 locked write");
    do_read(3, 1, 0, "R5 R9 unchanged after locked write");

    // R10 open the latch, then fill every word
    sel(); special(2'b11); desel();
    for (int a = 0; a < NW; a++) begin
      do_write(a, wpat(a), 1'b1, "R7 R10 word write");
      mdl[a] = wpat(a);
    end
    do_read(0, NW + 2, 0, "R4 sweep with wrap");
    do_read(NW - 3, 5, 2, "R2 leading zeros, R4 wrap");

    // R9 erase one word, then overwrite without erase
    sel(); header(2'b11, 5); finish_prog(1'b1, "R9 erase");
    mdl[5] = 16'hFFFF;
    do_write(6, 16'h0F0F, 1'b1, "R9 overwrite"); mdl[6] = 16'h0F0F;
    do_read(0, NW, 0, "R9 after erase");

    // R12 byte organisation
    org_wide = 1'b0;
    for (int b = 0; b < NB; b++) begin
      do_write(b, {8'd0, bpat(b)}, 1'b1, "R12 byte write");
      if (b[0]) mdl[b >> 1][15:8] = bpat(b); else mdl[b >> 1][7:0] = bpat(b);
    end
    do_read(NB - 2, NB + 2, 0, "R12 byte sweep");
    org_wide = 1'b1;
    do_read(0, NW, 0, "R12 byte lanes in words");

    // R10 write-all and erase-all, both organisations
    sel(); special(2'b01); send(32'h3C5A, 16); finish_prog(1'b1, "R10 write-all wide");
    for (int i = 0; i < NW; i++) mdl[i] = 16'h3C5A;
    do_read(0, NW, 0, "R10 write-all wide");
    org_wide = 1'b0;
    sel(); special(2'b01); send(32'h96, 8); finish_prog(1'b1, "R12 write-all byte");
    for (int i = 0; i < NW; i++) mdl[i] = 16'h9696;
    org_wide = 1'b1;
    do_read(0, NW, 0, "R12 write-all byte fill");
    sel(); special(2'b10); finish_prog(1'b1, "R9 erase-all");
    for (int i = 0; i < NW; i++) mdl[i] = 16'hFFFF;
    do_read(0, NW, 0, "R9 erase-all");

    // R11 a frame inside a busy cycle is ignored
    sel(); header(2'b01, 2); send(32'hAAAA, 16); desel();
    sel(); header(2'b01, 7); send(32'h1357, 16); desel();
    wait_clk(PROG + 20);
    mdl[2] = 16'hAAAA;
    do_read(2, 6, 0, "R11 busy frame ignored");

    // R7 frame cut short does nothing
    sel(); send({29'd0, 3'b101}, 3); send(32'd1, 2); desel();
    sel(); wait_clk(3);
    chk("R7 no cycle after partial frame", {31'd0, sdo_en}, 32'd0);
    desel();
    do_read(0, 2, 0, "R7 partial frame");

    // R5 R6 close the latch; writes ignored, reads still work
    sel(); special(2'b00); desel();
    do_write(4, 16'h0000, 1'b0, "R5 write after close");
    sel(); special(2'b10); finish_prog(1'b0, "R5 erase-all after close");
    do_read(0, NW, 0, "R6 read while locked");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule